// File: doc/BRIEF.md
# Sigma-Delta Modulator Calibration Sequencer

This controller runs in the master-clock domain next to a single-bit sigma-delta modulator. On a start pulse it holds the modulator in reset and waits for the modulator's data-valid flag. It then runs two measurements, one after the other. In the first, the offset-zero control output is held high. In the second, the gain-calibrate control output is held high. Each measurement begins with a settling wait. The block then counts the ones in a window of 2^WIN_LOG2 stream bits, each bit taken on a rising edge of the serial clock. Each count is compared with the ideal count for the measurement type and the input mode captured at start. The two differences are reported as signed error counts.

If data-valid falls during a window, the window is thrown away and the measurement starts again from its settling wait. Each such event uses up one retry. When the retry budget is used up, the run ends with an error. A result-valid flag marks a good pair of results. The flag drops as soon as the unipolar/bipolar select differs from the mode the results were taken in.

The stream input carries no back-pressure: the modulator cannot be stalled, so every rising serial-clock edge inside a window is consumed in the cycle it is seen. Start, status and result pins are plain level or pulse signals.

Top module: `sdm_cal_seq`

## Requirements
- R1: A start pulse accepted in idle raises the modulator reset output and busy in the next cycle. The reset output stays high for exactly RST_CYC cycles, and both calibration controls stay low while it is high.
- R2: After reset the block waits for data-valid high. It then needs SETTLE_CYC consecutive cycles with data-valid high before a window opens. A cycle with data-valid low restarts the settling count.
- R3: The offset measurement runs first. The offset-zero output is high through its settle wait and window. The offset-zero and gain-calibrate outputs are never high together.
- R4: The gain measurement follows the offset window directly. The gain-calibrate output is high through its settle wait and window.
- R5: A window holds 2^WIN_LOG2 samples. A sample is data_i in a cycle where sclk_i is high and was low in the previous cycle, and data-valid is high. Each result is the ones count minus the ideal count. The ideal counts are: offset, bipolar (bipolar_i=1 at start) = W/2; offset, unipolar (bipolar_i=0) = 3W/8; gain = 5W/8.
- R6: If data-valid falls during a window, the window is dropped, the retry count rises by one and the measurement resumes at its settle wait. A drop when MAX_RETRY retries are already used ends the run with done and err_o high, and leaves both results unchanged.
- R7: done_o is a one-cycle pulse in the cycle busy falls. Start pulses while busy have no effect on the sequence.
- R8: cal_ok_o rises with done after a good run if bipolar_i still matches the captured mode. It clears in the cycle after bipolar_i differs from that mode, and it is low after an error run.
- R9: After reset all outputs are low and both error counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| bipolar_i | input | 1 | Input mode select, 1 = bipolar, 0 = unipolar |
| dvalid_i | input | 1 | Modulator data-valid flag |
| sclk_i | input | 1 | Serial clock from the modulator, sampled in the clk domain |
| data_i | input | 1 | Modulator bit stream |
| mod_rst_o | output | 1 | Modulator reset control |
| zero_o | output | 1 | Offset-zero control |
| gcal_o | output | 1 | Gain-calibrate control |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Last run ended with the retry budget used up |
| cal_ok_o | output | 1 | Results valid for the current mode |
| off_err_o | output | WIN_LOG2+2 | Signed offset error count |
| gain_err_o | output | WIN_LOG2+2 | Signed gain error count |

## Verification
On every cycle the assertions check the following: the two calibration controls never overlap, and neither is high during modulator reset. Gain follows offset. A window opens only after a cycle with data-valid high. done is a single pulse that coincides with idle, and an error run never leaves the valid flag set. The window counter is checked to stay within the samples taken. Only the bench's scenarios can show that the error values are right for each mode and stream density, including negative ones. The same holds for the exact reset and settle lengths, a window recovering after one drop, error exit after the retry budget, and the valid flag dropping on a mode change.

// File: rtl/sdm_cal_pkg.sv
package sdm_cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_DVW,
    ST_SETTLE,
    ST_ACC
  } cal_st_e;
endpackage

// File: rtl/sdm_sclk_sampler.sv
module sdm_sclk_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic data_i,
  output logic rise_o,
  output logic bit_o
);
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_i;
  end

  // stream bit is valid at the serial clock's rising edge
  assign rise_o = sclk_i & ~sclk_q;
  assign bit_o  = data_i;
endmodule

// File: rtl/sdm_wait_timer.sv
module sdm_wait_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] lim_i,
  output logic         hit_o
);
  logic [W-1:0] cnt;

  assign hit_o = (cnt == lim_i);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (clr_i)        cnt <= '0;
    else if (en_i && !hit_o) cnt <= cnt + 1'b1;
  end

  assert_tmr_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i) |-> (cnt <= lim_i));
endmodule

// File: rtl/sdm_density_acc.sv
module sdm_density_acc #(
  parameter int LOG2 = 6,
  localparam int CW = LOG2 + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          smp_i,
  input  logic          bit_i,
  output logic [CW-1:0] ones_nxt_o,
  output logic          last_o
);
  logic [CW-1:0]   ones;
  logic [LOG2-1:0] samp;

  assign ones_nxt_o = ones + CW'(bit_i);
  assign last_o     = smp_i && (samp == {LOG2{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      ones <= '0;
      samp <= '0;
    end else if (smp_i) begin
      ones <= ones_nxt_o;
      samp <= samp + 1'b1;
    end
  end

  assert_ones_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_i |-> (ones <= CW'(samp)));
endmodule

// File: rtl/sdm_cal_seq.sv
module sdm_cal_seq
  import sdm_cal_pkg::*;
#(
  parameter int WIN_LOG2   = 6,
  parameter int SETTLE_CYC = 1000,
  parameter int RST_CYC    = 8,
  parameter int MAX_RETRY  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  bipolar_i,
  input  logic                  dvalid_i,
  input  logic                  sclk_i,
  input  logic                  data_i,
  output logic                  mod_rst_o,
  output logic                  zero_o,
  output logic                  gcal_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  err_o,
  output logic                  cal_ok_o,
  output logic [WIN_LOG2+1:0]   off_err_o,
  output logic [WIN_LOG2+1:0]   gain_err_o
);
  localparam int WIN  = 1 << WIN_LOG2;
  localparam int CW   = WIN_LOG2 + 1;
  localparam int EW   = WIN_LOG2 + 2;
  localparam int TMAX = (SETTLE_CYC > RST_CYC) ? SETTLE_CYC : RST_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int RW   = $clog2(MAX_RETRY + 2);
  localparam logic [EW-1:0] IDL_BIP  = EW'(WIN >> 1);
  localparam logic [EW-1:0] IDL_UNI  = EW'((WIN >> 2) + (WIN >> 3));
  localparam logic [EW-1:0] IDL_GAIN = EW'((WIN >> 1) + (WIN >> 3));

  cal_st_e st;
  logic phase_gain, mode_q, done_q, err_q, ok_q;
  logic [RW-1:0] retry_q;
  logic [EW-1:0] off_q, gain_q;

  logic rise, bit_s, tmr_hit, tmr_clr, tmr_en, smp, win_last;
  logic [TW-1:0] tmr_lim;
  logic [CW-1:0] ones_nxt;
  logic [EW-1:0] ideal;
  logic signed [EW-1:0] meas_err;

  sdm_sclk_sampler u_samp (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .data_i(data_i),
    .rise_o(rise), .bit_o(bit_s)
  );

  assign tmr_en  = (st == ST_RST) || (st == ST_SETTLE);
  assign tmr_clr = (st == ST_IDLE) || (st == ST_DVW) || (st == ST_ACC) ||
                   ((st == ST_SETTLE) && !dvalid_i);
  assign tmr_lim = (st == ST_RST) ? TW'(RST_CYC - 1) : TW'(SETTLE_CYC - 1);

  sdm_wait_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr), .en_i(tmr_en),
    .lim_i(tmr_lim), .hit_o(tmr_hit)
  );

  assign smp = (st == ST_ACC) && dvalid_i && rise;

  sdm_density_acc #(.LOG2(WIN_LOG2)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr_i(st != ST_ACC), .smp_i(smp),
    .bit_i(bit_s), .ones_nxt_o(ones_nxt), .last_o(win_last)
  );

  assign ideal    = phase_gain ? IDL_GAIN : (mode_q ? IDL_BIP : IDL_UNI);
  assign meas_err = $signed({1'b0, ones_nxt}) - $signed(ideal);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      phase_gain <= 1'b0;
      mode_q     <= 1'b0;
      retry_q    <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      ok_q       <= 1'b0;
      off_q      <= '0;
      gain_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (bipolar_i != mode_q) ok_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (start_i) begin
          st         <= ST_RST;
          retry_q    <= '0;
          mode_q     <= bipolar_i;
          err_q      <= 1'b0;
          ok_q       <= 1'b0;
          phase_gain <= 1'b0;
        end
        ST_RST:    if (tmr_hit) st <= ST_DVW;
        ST_DVW:    if (dvalid_i) st <= ST_SETTLE;
        ST_SETTLE: if (dvalid_i && tmr_hit) st <= ST_ACC;
        ST_ACC: begin
          if (!dvalid_i) begin
            if (retry_q == RW'(MAX_RETRY)) begin
              st     <= ST_IDLE;
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end else begin
              retry_q <= retry_q + 1'b1;
              st      <= ST_SETTLE;
            end
          end else if (win_last) begin
            if (!phase_gain) begin
              off_q      <= meas_err;
              phase_gain <= 1'b1;
              st         <= ST_SETTLE;
            end else begin
              gain_q <= meas_err;
              st     <= ST_IDLE;
              done_q <= 1'b1;
              ok_q   <= (bipolar_i == mode_q);
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mod_rst_o  = (st == ST_RST);
  assign zero_o     = ((st == ST_SETTLE) || (st == ST_ACC)) && !phase_gain;
  assign gcal_o     = ((st == ST_SETTLE) || (st == ST_ACC)) && phase_gain;
  assign busy_o     = (st != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign cal_ok_o   = ok_q;
  assign off_err_o  = off_q;
  assign gain_err_o = gain_q;

  assert_ctl_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(zero_o && gcal_o));
  assert_rst_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mod_rst_o |-> (!zero_o && !gcal_o));
  assert_gain_after_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gcal_o) |-> $past(zero_o));
  assert_win_after_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_ACC) && ($past(st) == ST_SETTLE)) |-> $past(dvalid_i));
  assert_err_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> done_o);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  assert_ok_not_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_ok_o |-> !err_o);
endmodule

// File: tb/sdm_cal_seq_tb.sv
module sdm_cal_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LOG2 = 6;
  localparam int WIN = 1 << LOG2;
  localparam int SETTLE = 1000;
  localparam int RSTC = 8;
  localparam int MAXR = 2;
  localparam int EW = LOG2 + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, bipolar_i = 1'b1;
  logic dvalid_i = 1'b1, sclk_i = 1'b0, data_i = 1'b0;
  logic mod_rst_o, zero_o, gcal_o, busy_o, done_o, err_o, cal_ok_o;
  logic [EW-1:0] off_err_o, gain_err_o;

  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdm_cal_seq #(.WIN_LOG2(LOG2), .SETTLE_CYC(SETTLE), .RST_CYC(RSTC), .MAX_RETRY(MAXR)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bipolar_i(bipolar_i),
    .dvalid_i(dvalid_i), .sclk_i(sclk_i), .data_i(data_i),
    .mod_rst_o(mod_rst_o), .zero_o(zero_o), .gcal_o(gcal_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .cal_ok_o(cal_ok_o),
    .off_err_o(off_err_o), .gain_err_o(gain_err_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model (0 idle,1 reset,2 wait valid,3 settle,4 window)
  int m_st, m_t, m_retry, m_ones, m_samp, m_off, m_gain;
  bit m_phase, m_mode, m_done, m_err, m_ok, m_prev;

  always @(posedge clk) begin
    bit rise;
    int e;
    if (!rst_n) begin
      m_st = 0; m_t = 0; m_retry = 0; m_ones = 0; m_samp = 0; m_off = 0; m_gain = 0;
      m_phase = 0; m_mode = 0; m_done = 0; m_err = 0; m_ok = 0; m_prev = 0;
    end else begin
      rise = sclk_i && !m_prev;
      m_prev = sclk_i;
      m_done = 0;
      if (bipolar_i != m_mode) m_ok = 0;
      case (m_st)
        0: if (start_i) begin
          m_st = 1; m_t = 0; m_retry = 0; m_mode = bipolar_i; m_err = 0; m_ok = 0; m_phase = 0;
        end
        1: if (m_t == RSTC-1) m_st = 2; else m_t++;
        2: if (dvalid_i) begin m_st = 3; m_t = 0; end
        3: if (!dvalid_i) m_t = 0;
           else if (m_t == SETTLE-1) begin m_st = 4; m_ones = 0; m_samp = 0; end
           else m_t++;
        4: if (!dvalid_i) begin
             if (m_retry == MAXR) begin m_st = 0; m_done = 1; m_err = 1; end
             else begin m_retry++; m_st = 3; m_t = 0; end
           end else if (rise) begin
             m_ones += int'(data_i);
             m_samp++;
             if (m_samp == WIN) begin
               e = m_ones - (m_phase ? 5*WIN/8 : (m_mode ? WIN/2 : 3*WIN/8));
               if (!m_phase) begin m_off = e; m_phase = 1; m_st = 3; m_t = 0; end
               else begin m_gain = e; m_st = 0; m_done = 1; m_ok = (bipolar_i == m_mode); end
             end
           end
        default: m_st = 0;
      endcase
    end
  end

  // ---------------- per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 1) begin
      chk(mod_rst_o === (m_st == 1), "R1 mod_rst", int'(mod_rst_o), int'(m_st == 1));
      chk(zero_o === ((m_st == 3 || m_st == 4) && !m_phase), "R3 zero", int'(zero_o), int'((m_st == 3 || m_st == 4) && !m_phase));
      chk(gcal_o === ((m_st == 3 || m_st == 4) && m_phase), "R4 gcal", int'(gcal_o), int'((m_st == 3 || m_st == 4) && m_phase));
      chk(busy_o === (m_st != 0), "R7 busy", int'(busy_o), int'(m_st != 0));
      chk(done_o === m_done, "R7 done", int'(done_o), int'(m_done));
      chk(err_o === m_err, "R6 err", int'(err_o), int'(m_err));
      chk(cal_ok_o === m_ok, "R8 cal_ok", int'(cal_ok_o), int'(m_ok));
      chk($signed(off_err_o) == m_off, "R5 off_err", int'($signed(off_err_o)), m_off);
      chk($signed(gain_err_o) == m_gain, "R5 gain_err", int'($signed(gain_err_o)), m_gain);
    end
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // ---------------- stream and data-valid source
  int ph = 0, bi = 0, lowc = 0, d_off = 4, d_gain = 5;
  bit drop_req = 0;
  always @(negedge clk) begin
    ph = (ph + 1) % 4;
    sclk_i = (ph >= 2);
    if (ph == 0) begin
      data_i = ((bi % 8) < (gcal_o ? d_gain : d_off));
      bi++;
    end
    if (mod_rst_o) lowc = 20;
    else if (drop_req) begin lowc = 20; drop_req = 0; end
    dvalid_i = (lowc == 0);
    if (lowc > 0) lowc--;
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic run_start();
    start_i = 1'b1; tick(); start_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && !m_done; i++) tick();
    @(negedge clk); tick();
  endtask

  task automatic drop_in_window();
    for (int i = 0; i < 20000 && m_st != 4; i++) tick();
    repeat (30) tick();
    drop_req = 1;
    for (int i = 0; i < 100 && m_st == 4; i++) tick();
  endtask

  initial begin
    repeat (3) tick();
    @(negedge clk);
    // R9 reset state
    chk(!mod_rst_o && !zero_o && !gcal_o && !busy_o && !done_o && !err_o && !cal_ok_o,
        "R9 outputs low in reset", int'(busy_o), 0);
    chk(off_err_o == '0 && gain_err_o == '0, "R9 errors zero", int'(off_err_o), 0);
    tick(); rst_n = 1'b1; tick();

    // bipolar, ideal densities; extra start while busy is ignored (R7)
    bipolar_i = 1; d_off = 4; d_gain = 5;
    run_start();
    @(negedge clk);
    chk(mod_rst_o === 1'b1, "R1 reset after start", int'(mod_rst_o), 1);
    repeat (RSTC) tick();
    @(negedge clk);
    chk(mod_rst_o === 1'b0, "R1 reset length", int'(mod_rst_o), 0);
    repeat (500) tick();
    run_start();
    wait_done();
    chk($signed(off_err_o) == 0, "R5 bipolar offset", int'($signed(off_err_o)), 0);
    chk($signed(gain_err_o) == 0, "R5 gain ideal", int'($signed(gain_err_o)), 0);
    chk(cal_ok_o === 1'b1, "R8 ok after run", int'(cal_ok_o), 1);

    // R8 mode change drops validity
    bipolar_i = 0; tick(); tick();
    @(negedge clk);
    chk(cal_ok_o === 1'b0, "R8 ok cleared on mode change", int'(cal_ok_o), 0);

    // unipolar, negative offset and positive gain error
    d_off = 2; d_gain = 6;
    run_start();
    wait_done();
    chk($signed(off_err_o) == 16 - 24, "R5 unipolar offset", int'($signed(off_err_o)), -8);
    chk($signed(gain_err_o) == 48 - 40, "R5 gain high", int'($signed(gain_err_o)), 8);

    // R6 single drop recovers
    bipolar_i = 1; d_off = 5; d_gain = 3;
    run_start();
    drop_in_window();
    wait_done();
    chk(err_o === 1'b0, "R6 one retry no error", int'(err_o), 0);
    chk($signed(off_err_o) == 40 - 32, "R6 offset after retry", int'($signed(off_err_o)), 8);
    chk($signed(gain_err_o) == 24 - 40, "R5 gain low", int'($signed(gain_err_o)), -16);

    // R6 retry budget exhausted, results kept
    d_off = 4; d_gain = 5;
    run_start();
    for (int k = 0; k <= MAXR; k++) drop_in_window();
    wait_done();
    chk(err_o === 1'b1, "R6 error after retries", int'(err_o), 1);
    chk($signed(gain_err_o) == -16, "R6 results unchanged", int'($signed(gain_err_o)), -16);
    chk(cal_ok_o === 1'b0, "R8 not ok after error", int'(cal_ok_o), 0);

    repeat (5) tick();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule